// File: doc/BRIEF.md
# Boot Link Selection Arbiter

This block decides, once per boot session, which host link a loader will talk through. Every clock cycle it looks at four activity indications: a USB cable being attached, a 0x7F sync byte recognised on serial port A, the same on serial port B, and a frame edge on the CAN receive line. When one or more of them is active it picks the one with the highest priority. That link is then locked in and every other link stays disabled until the next reset.

A serial link is granted at once. The USB and CAN links both depend on an external reference clock. For either of them the arbiter first asks for a clock measurement and holds the grant back. It waits for a measured frequency code, qualified by a valid strobe.
- If the code names one of the three allowed frequencies, the grant is confirmed. For USB it also pulses a request to move the system and USB clocks to 48 MHz.
- If the code is the invalid value, the arbiter pulses a system-reset request and stays idle with nothing granted.

Top module: `boot_arb_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, grant is 0000, linkReady, clkCheckReq, clkSwitchReq and sysResetReq are all 0.
- R2: When several activity inputs are high in the same cycle, the winner follows a fixed order: usbAttach first (grant bit 0), then syncA (bit 1), then syncB (bit 2), then canEdge (bit 3).
- R3: A serial winner (bit 1 or 2) shows up on grant, with linkReady high, at the first clock edge after the activity is sampled. No clock check is requested for it.
- R4: A USB or CAN winner raises clkCheckReq from the next edge on. Grant stays 0000 until a clock code arrives with clkCodeValid high.
- R5: With clkCodeValid high during the wait, a clkCode of 00 (8 MHz), 01 (14.7456 MHz) or 10 (25 MHz) sets the pending grant bit at the next edge, raises linkReady and drops clkCheckReq.
- R6: When R5 confirms a USB grant, clkSwitchReq is high for exactly one cycle, aligned with the grant appearing. A confirmed CAN grant never raises clkSwitchReq.
- R7: clkCode 11 (invalid) with clkCodeValid high during the wait gives a one-cycle sysResetReq pulse. After that, grant stays 0000 and all activity inputs are ignored until reset.
- R8: Once granted, the grant never changes during the session. A USB attach or any other activity after a serial or CAN grant has no effect on it.
- R9: grant never has more than one bit set, and each request pulse lasts a single cycle.
- R10: clkCodeValid has no effect while no USB or CAN check is pending.
- R11: Activity on other links during the clock wait does not replace the pending winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usbAttach | input | 1 | USB cable present |
| syncA | input | 1 | Sync byte seen on serial port A |
| syncB | input | 1 | Sync byte seen on serial port B |
| canEdge | input | 1 | Frame edge seen on the CAN receive line |
| clkCodeValid | input | 1 | Qualifies clkCode |
| clkCode | input | 2 | Measured reference frequency: 00 8 MHz, 01 14.7456 MHz, 10 25 MHz, 11 invalid |
| grant | output | 4 | One-hot link enable: bit0 USB, bit1 serial A, bit2 serial B, bit3 CAN |
| linkReady | output | 1 | Selection confirmed |
| clkCheckReq | output | 1 | Waiting for a reference clock measurement |
| clkSwitchReq | output | 1 | One-cycle request for 48 MHz system and USB clocks |
| sysResetReq | output | 1 | One-cycle system reset request |

## Verification
The assertions check on every cycle the properties that need no scenario context:
- grant stays one-hot or empty, and a nonzero grant stays frozen;
- no grant is present while a clock check is pending;
- the request pulses are one cycle wide;
- a clock switch goes only with a USB grant, and a reset request never coexists with a grant.

Only the bench scenarios can show the rest:
- the priority order across combinations of simultaneous activity;
- that each legal code confirms and the invalid code gives up;
- that the pending winner survives competing activity during the wait;
- that late attaches, stray strobes and activity after a failure are ignored.

// File: rtl/boot_arb_pkg.sv
package boot_arb_pkg;

  typedef enum logic [1:0] {
    ST_POLL    = 2'd0,
    ST_CLKWAIT = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_HALT    = 2'd3
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;      // latch the priority winner as candidate
    logic commit;       // copy winner (capture) or candidate into grant
    logic pulseSwitch;  // emit clock switch request
    logic pulseReset;   // emit system reset request
  } arbStrobe_t;

endpackage

// File: rtl/boot_arb_dp.sv
module boot_arb_dp
  import boot_arb_pkg::*;
#(
  parameter int NLINK = 4,
  parameter logic [NLINK-1:0] CLK_MASK = 4'b1001,
  parameter logic [NLINK-1:0] SWITCH_MASK = 4'b0001
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NLINK-1:0] act,
  input  arbStrobe_t       strobe,
  output logic             anyAct,
  output logic             pickNeedsClk,
  output logic             candNeedsSwitch,
  output logic [NLINK-1:0] grant,
  output logic             clkSwitchReq,
  output logic             sysResetReq
);

  logic [NLINK-1:0] pick;
  logic [NLINK:0]   lowerSeen;
  logic [NLINK-1:0] candReg;
  logic [NLINK-1:0] grantReg;
  logic             switchReg;
  logic             resetReg;

  assign lowerSeen[0] = 1'b0;

  // lower index wins
  for (genvar i = 0; i < NLINK; i++) begin : g_prio
    assign pick[i]         = act[i] & ~lowerSeen[i];
    assign lowerSeen[i+1]  = lowerSeen[i] | act[i];
  end

  assign anyAct          = lowerSeen[NLINK];
  assign pickNeedsClk    = |(pick & CLK_MASK);
  assign candNeedsSwitch = |(candReg & SWITCH_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candReg   <= '0;
      grantReg  <= '0;
      switchReg <= 1'b0;
      resetReg  <= 1'b0;
    end else begin
      if (strobe.capture) candReg <= pick;
      if (strobe.commit)  grantReg <= strobe.capture ? pick : candReg;
      switchReg <= strobe.pulseSwitch;
      resetReg  <= strobe.pulseReset;
    end
  end

  assign grant        = grantReg;
  assign clkSwitchReq = switchReg;
  assign sysResetReq  = resetReg;

endmodule

// File: rtl/boot_arb_ctrl.sv
module boot_arb_ctrl
  import boot_arb_pkg::*;
#(
  parameter int CODE_W = 2,
  parameter logic [CODE_W-1:0] BAD_CODE = 2'b11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              anyAct,
  input  logic              pickNeedsClk,
  input  logic              candNeedsSwitch,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] code,
  output arbStrobe_t        strobe,
  output logic              clkCheckReq,
  output logic              linkReady
);

  arbState_t state, stateNext;
  logic      codeOk;

  assign codeOk = (code != BAD_CODE);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_POLL: begin
        if (anyAct) begin
          strobe.capture = 1'b1;
          if (pickNeedsClk) begin
            stateNext = ST_CLKWAIT;
          end else begin
            strobe.commit = 1'b1;
            stateNext     = ST_ACTIVE;
          end
        end
      end
      ST_CLKWAIT: begin
        if (codeValid) begin
          if (codeOk) begin
            strobe.commit      = 1'b1;
            strobe.pulseSwitch = candNeedsSwitch;
            stateNext          = ST_ACTIVE;
          end else begin
            strobe.pulseReset = 1'b1;
            stateNext         = ST_HALT;
          end
        end
      end
      ST_ACTIVE: stateNext = ST_ACTIVE;
      ST_HALT:   stateNext = ST_HALT;
      default:   stateNext = ST_POLL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_POLL;
    else       state <= stateNext;
  end

  assign clkCheckReq = (state == ST_CLKWAIT);
  assign linkReady   = (state == ST_ACTIVE);

endmodule

// File: rtl/boot_arb_top.sv
module boot_arb_top
  import boot_arb_pkg::*;
#(
  parameter int NLINK  = 4,
  parameter int CODE_W = 2,
  parameter logic [NLINK-1:0]  CLK_MASK    = 4'b1001,
  parameter logic [NLINK-1:0]  SWITCH_MASK = 4'b0001,
  parameter logic [CODE_W-1:0] BAD_CODE    = 2'b11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usbAttach,
  input  logic              syncA,
  input  logic              syncB,
  input  logic              canEdge,
  input  logic              clkCodeValid,
  input  logic [CODE_W-1:0] clkCode,
  output logic [NLINK-1:0]  grant,
  output logic              linkReady,
  output logic              clkCheckReq,
  output logic              clkSwitchReq,
  output logic              sysResetReq
);

  arbStrobe_t       strobe;
  logic             anyAct;
  logic             pickNeedsClk;
  logic             candNeedsSwitch;
  logic [NLINK-1:0] act;

  assign act = NLINK'({canEdge, syncB, syncA, usbAttach});

  boot_arb_ctrl #(.CODE_W(CODE_W), .BAD_CODE(BAD_CODE)) u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .anyAct          (anyAct),
    .pickNeedsClk    (pickNeedsClk),
    .candNeedsSwitch (candNeedsSwitch),
    .codeValid       (clkCodeValid),
    .code            (clkCode),
    .strobe          (strobe),
    .clkCheckReq     (clkCheckReq),
    .linkReady       (linkReady)
  );

  boot_arb_dp #(.NLINK(NLINK), .CLK_MASK(CLK_MASK), .SWITCH_MASK(SWITCH_MASK)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .act             (act),
    .strobe          (strobe),
    .anyAct          (anyAct),
    .pickNeedsClk    (pickNeedsClk),
    .candNeedsSwitch (candNeedsSwitch),
    .grant           (grant),
    .clkSwitchReq    (clkSwitchReq),
    .sysResetReq     (sysResetReq)
  );

endmodule

// File: rtl/boot_arb_chk.sv
module boot_arb_chk #(
  parameter int NLINK = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [NLINK-1:0] grant,
  input logic             linkReady,
  input logic             clkCheckReq,
  input logic             clkSwitchReq,
  input logic             sysResetReq
);

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  p_reset_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> !sysResetReq);

  p_switch_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    clkSwitchReq |=> !clkSwitchReq);

  p_grant_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |=> (grant == $past(grant)));

  p_wait_nogrant_r4: assert property (@(posedge clk) disable iff (!rstN)
    clkCheckReq |-> (grant == '0));

  p_switch_usb_r6: assert property (@(posedge clk) disable iff (!rstN)
    clkSwitchReq |-> (grant[0] && linkReady));

  p_reset_nogrant_r7: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> ((grant == '0) && !linkReady && !clkCheckReq));

  p_ready_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    linkReady |-> $onehot(grant));

endmodule

bind boot_arb_top boot_arb_chk #(.NLINK(NLINK)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .grant        (grant),
  .linkReady    (linkReady),
  .clkCheckReq  (clkCheckReq),
  .clkSwitchReq (clkSwitchReq),
  .sysResetReq  (sysResetReq)
);

// File: tb/sim_boot_arb_top.sv
module sim_boot_arb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       usbAttach = 1'b0, syncA = 1'b0, syncB = 1'b0, canEdge = 1'b0;
  logic       clkCodeValid = 1'b0;
  logic [1:0] clkCode = 2'b00;
  logic [3:0] grant;
  logic       linkReady, clkCheckReq, clkSwitchReq, sysResetReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  boot_arb_top u0 (
    .clk(clk), .rstN(rstN), .usbAttach(usbAttach), .syncA(syncA), .syncB(syncB),
    .canEdge(canEdge), .clkCodeValid(clkCodeValid), .clkCode(clkCode),
    .grant(grant), .linkReady(linkReady), .clkCheckReq(clkCheckReq),
    .clkSwitchReq(clkSwitchReq), .sysResetReq(sysResetReq)
  );

  // {act[3:0], code[1:0], needClk, expGrant[3:0], expSwitch, expReset, expReady}
  localparam int NVEC = 10;
  localparam logic [13:0] VEC [NVEC] = '{
    {4'b0001, 2'b00, 1'b1, 4'b0001, 1'b1, 1'b0, 1'b1},  // R6 usb ok 8 MHz
    {4'b0010, 2'b00, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b1},  // R3 serial A
    {4'b0100, 2'b00, 1'b0, 4'b0100, 1'b0, 1'b0, 1'b1},  // R3 serial B
    {4'b1000, 2'b01, 1'b1, 4'b1000, 1'b0, 1'b0, 1'b1},  // R5 can 14.7456
    {4'b1000, 2'b11, 1'b1, 4'b0000, 1'b0, 1'b1, 1'b0},  // R7 can bad
    {4'b0001, 2'b11, 1'b1, 4'b0000, 1'b0, 1'b1, 1'b0},  // R7 usb bad
    {4'b1111, 2'b10, 1'b1, 4'b0001, 1'b1, 1'b0, 1'b1},  // R2 all -> usb
    {4'b1110, 2'b00, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b1},  // R2 -> serial A
    {4'b1100, 2'b00, 1'b0, 4'b0100, 1'b0, 1'b0, 1'b1},  // R2 -> serial B
    {4'b1001, 2'b10, 1'b1, 4'b0001, 1'b1, 1'b0, 1'b1}   // R2 usb over can
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setAct(input logic [3:0] a);
    usbAttach = a[0]; syncA = a[1]; syncB = a[2]; canEdge = a[3];
  endtask

  task automatic doReset();
    @(negedge clk);
    setAct(4'b0); clkCodeValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // pulse activity for one cycle; returns at the following negedge
  task automatic pulseAct(input logic [3:0] a);
    setAct(a);
    @(negedge clk);
    setAct(4'b0);
  endtask

  task automatic pulseCode(input logic [1:0] c);
    clkCodeValid = 1'b1; clkCode = c;
    @(negedge clk);
    clkCodeValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    check(grant == 4'b0 && !linkReady && !clkCheckReq && !clkSwitchReq && !sysResetReq,
          "R1 during reset", int'({grant, linkReady, clkCheckReq}), 0);
    doReset();
    @(negedge clk);
    check(grant == 4'b0 && !linkReady && !clkCheckReq && !clkSwitchReq && !sysResetReq,
          "R1 after reset", int'({grant, linkReady, clkCheckReq}), 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] a; logic [1:0] c; logic nc; logic [3:0] eg; logic es, er, ey;
      {a, c, nc, eg, es, er, ey} = VEC[v];
      doReset();
      pulseAct(a);
      if (nc) begin
        check(clkCheckReq && grant == 4'b0, "R4 wait for clock", int'({clkCheckReq, grant}), 16);
        @(negedge clk);
        check(clkCheckReq && grant == 4'b0, "R4 still waiting", int'({clkCheckReq, grant}), 16);
        pulseCode(c);
        check(grant == eg, "R2/R5/R7 grant", grant, eg);
        check(clkSwitchReq == es, "R6 switch pulse", clkSwitchReq, es);
        check(sysResetReq == er, "R7 reset pulse", sysResetReq, er);
        check(linkReady == ey && !clkCheckReq, "R5 ready", linkReady, ey);
        @(negedge clk);
        check(!clkSwitchReq && !sysResetReq, "R9 single pulse",
              int'({clkSwitchReq, sysResetReq}), 0);
        check(grant == eg, "R8 grant held", grant, eg);
      end else begin
        check(grant == eg && linkReady && !clkCheckReq, "R3 serial grant",
              int'({grant, linkReady, clkCheckReq}), int'({eg, 1'b1, 1'b0}));
        check(!clkSwitchReq && !sysResetReq, "R3 no requests",
              int'({clkSwitchReq, sysResetReq}), 0);
      end
    end

    // R10: stray valid strobe in poll
    doReset();
    pulseCode(2'b11);
    check(grant == 0 && !sysResetReq && !clkSwitchReq && !linkReady, "R10 stray bad code",
          int'({grant, sysResetReq}), 0);
    pulseAct(4'b0010);
    check(grant == 4'b0010, "R10 still polling", grant, 2);

    // R8: late USB attach after serial grant
    pulseAct(4'b0001);
    @(negedge clk);
    check(grant == 4'b0010 && !clkCheckReq, "R8 late usb ignored", grant, 2);
    pulseCode(2'b11);
    check(grant == 4'b0010 && !sysResetReq, "R10 strobe after grant", grant, 2);

    // R8: CAN granted then usb
    doReset();
    pulseAct(4'b1000);
    pulseCode(2'b00);
    pulseAct(4'b0111);
    @(negedge clk);
    check(grant == 4'b1000 && linkReady, "R8 can grant held", grant, 8);

    // R11: activity during wait
    doReset();
    pulseAct(4'b1000);
    pulseAct(4'b0011);
    check(clkCheckReq && grant == 0, "R11 wait undisturbed", int'({clkCheckReq, grant}), 16);
    pulseCode(2'b10);
    check(grant == 4'b1000 && !clkSwitchReq, "R11 can kept", grant, 8);

    // R7: halted ignores activity
    doReset();
    pulseAct(4'b0001);
    pulseCode(2'b11);
    @(negedge clk);
    pulseAct(4'b0010);
    @(negedge clk);
    check(grant == 0 && !linkReady && !clkCheckReq, "R7 halt ignores activity",
          int'({grant, linkReady}), 0);
    pulseCode(2'b00);
    check(grant == 0 && !clkSwitchReq && !sysResetReq, "R7 halt ignores code", grant, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule